// File: doc/BRIEF.md
# Periodic Down-Counter Tick Timer

This block is a 24-bit down-counter that produces a steady time base for an operating system or scheduler. Software programs a reload value and picks a count source: every core clock cycle, or a single-cycle tick-enable pulse from a slower reference. Then it enables the counter. Each time the count passes from one to zero, the block sets a sticky status flag and can emit an interrupt request pulse. At the following step the counter is refilled from the reload register, so a reload value of N gives a period of N+1 count steps.

Software accesses the block through a single-cycle register port with four 32-bit word registers: control/status, reload, current count and a read-only calibration word. Read data is registered and appears on the cycle after the access. Reading the control/status word also acknowledges the flag. Writing the current-count word restarts the count from zero.

Top module: `tick_timer`

## Requirements
- R1: After a synchronous reset, the enable, interrupt-enable and source-select bits, the reload value, the count, the flag, `irq` and `bus_rdata` are all zero.
- R2: A read (`bus_sel`=1, `bus_wr`=0) updates `bus_rdata` on the next rising edge; between reads `bus_rdata` holds its value. Word offsets are 0x0 control/status, 0x4 reload, 0x8 current count and 0xC calibration. In the control/status word, bit 0 is enable, bit 1 is interrupt enable, bit 2 is source select and bit 16 is the zero flag. Reload and count read back zero-extended in bits 23:0.
- R3: A count step occurs only while enable is 1. With source select 1 the counter steps every cycle; with source select 0 it steps only in cycles where `ref_tick` is 1. Without a step the count holds.
- R4: A step from a nonzero count N gives N-1. A step from 1 to 0 sets the flag. A step taken while the count is 0 loads the reload value.
- R5: A write of any data to offset 0x8 forces the count to 0 and clears the flag. This takes precedence over a step in the same cycle.
- R6: When interrupt enable is 1, a step from 1 to 0 makes `irq` high for exactly the one cycle after that edge. When interrupt enable is 0, `irq` stays low, although the flag is still set.
- R7: A read of offset 0x0 returns the flag as it was before the access and clears it afterwards. If a 1-to-0 step happens in the same cycle as the read, the flag ends up set.
- R8: With a reload value of 0, the counter stays at 0 while enabled, and neither the flag nor `irq` is ever raised.
- R9: A write to the reload register does not change the current count. The new value is used only at the next step from 0.
- R10: Offset 0xC reads bit 31 = parameter CAL_NOREF, bit 30 = CAL_SKEW and bits 23:0 = CAL_TENMS, with all other bits 0. Writes to it have no effect.
- R11: Reserved bits read as 0, and writes to them are ignored; this includes a write of 1 to bit 16, which does not set the flag. An access whose address is not word-aligned, or is above 0xC, reads 0 and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | Reference tick enable, used when source select is 0 |
| bus_sel | input | 1 | Register access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (4) | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after a read |
| irq | output | 1 | One-cycle interrupt request pulse on reaching zero |

## Verification
The hardest case to produce is a status read that lands on the same edge as the 1-to-0 step. In that case the read must return the old flag while the flag is still left set. The bench counts the reference source one pulse at a time, so the count value is known exactly. It then issues a single operation that raises `ref_tick` together with the status read when the count is 1, and it reads the status word twice more afterwards. Core-clock mode is checked by back-to-back reads of the count, whose values follow directly from the cycle in which enable was written.

// File: rtl/tt_pkg.sv
package tt_pkg;
  localparam int DATA_W   = 32;
  localparam int EN_POS   = 0;
  localparam int IE_POS   = 1;
  localparam int SRC_POS  = 2;
  localparam int FLAG_POS = 16;
  localparam int NOREF_POS = 31;
  localparam int SKEW_POS  = 30;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_RLD  = 2'd1,
    REG_CUR  = 2'd2,
    REG_CAL  = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic src;
    logic ie;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/tt_counter.sv
module tt_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             src,
  input  logic             ref_tick,
  input  logic             wr_cur,
  input  logic [CNT_W-1:0] rld,
  output logic [CNT_W-1:0] cnt,
  output logic             hit_zero
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic step;

  assign step     = en & (src | ref_tick);
  assign hit_zero = step & ~wr_cur & (cnt == ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (wr_cur) begin
      cnt <= '0;
    end else if (step) begin
      if (cnt == '0) cnt <= rld;
      else           cnt <= cnt - ONE;
    end
  end

  AST_OFF_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!en && !wr_cur) |=> $stable(cnt)); // R3
  AST_CUR_CLEAR: assert property (@(posedge clk) disable iff (rst)
    wr_cur |=> (cnt == '0)); // R5
  AST_PARK_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rld == '0 && cnt == '0) |=> (cnt == '0)); // R8
  AST_HIT_LANDS: assert property (@(posedge clk) disable iff (rst)
    hit_zero |=> (cnt == '0)); // R4
endmodule

// File: rtl/tt_flag.sv
module tt_flag (
  input  logic clk,
  input  logic rst,
  input  logic hit_zero,
  input  logic rd_ctrl,
  input  logic wr_cur,
  input  logic ie,
  output logic flag,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
      irq  <= 1'b0;
    end else begin
      if (hit_zero)               flag <= 1'b1;
      else if (rd_ctrl || wr_cur) flag <= 1'b0;
      irq <= hit_zero & ie;
    end
  end

  AST_FLAG_ON_HIT: assert property (@(posedge clk) disable iff (rst)
    hit_zero |=> flag); // R4
  AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(ie)); // R6
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq); // R6
  AST_RD_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (rd_ctrl && !hit_zero) |=> !flag); // R7
endmodule

// File: rtl/tt_regfile.sv
module tt_regfile
  import tt_pkg::*;
#(
  parameter int               CNT_W     = 24,
  parameter int               ADDR_W    = 4,
  parameter bit               CAL_NOREF = 1'b0,
  parameter bit               CAL_SKEW  = 1'b0,
  parameter logic [CNT_W-1:0] CAL_TENMS = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              flag,
  output ctrl_t             ctrl,
  output logic [CNT_W-1:0]  rld,
  output logic              wr_cur,
  output logic              rd_ctrl,
  output logic [DATA_W-1:0] bus_rdata
);
  logic          addr_ok;
  logic          wr_hit;
  logic          rd_hit;
  reg_sel_e      idx;
  logic [DATA_W-1:0] rd_word;
  logic [DATA_W-1:0] cal_word;
  logic          unused_wdata;

  assign unused_wdata = ^bus_wdata[DATA_W-1:CNT_W];
  assign addr_ok = (bus_addr[1:0] == 2'b00) && ((bus_addr >> 4) == '0);
  assign idx     = reg_sel_e'(bus_addr[3:2]);
  assign wr_hit  = bus_sel & bus_wr & addr_ok;
  assign rd_hit  = bus_sel & ~bus_wr & addr_ok;
  assign wr_cur  = wr_hit && (idx == REG_CUR);
  assign rd_ctrl = rd_hit && (idx == REG_CTRL);

  always_comb begin
    cal_word              = '0;
    cal_word[NOREF_POS]   = CAL_NOREF;
    cal_word[SKEW_POS]    = CAL_SKEW;
    cal_word[CNT_W-1:0]   = CAL_TENMS;
  end

  always_comb begin
    rd_word = '0;
    unique case (idx)
      REG_CTRL: begin
        rd_word[EN_POS]   = ctrl.en;
        rd_word[IE_POS]   = ctrl.ie;
        rd_word[SRC_POS]  = ctrl.src;
        rd_word[FLAG_POS] = flag;
      end
      REG_RLD: rd_word[CNT_W-1:0] = rld;
      REG_CUR: rd_word[CNT_W-1:0] = cnt;
      REG_CAL: rd_word = cal_word;
      default: rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
      rld  <= '0;
    end else if (wr_hit) begin
      if (idx == REG_CTRL) begin
        ctrl.en  <= bus_wdata[EN_POS];
        ctrl.ie  <= bus_wdata[IE_POS];
        ctrl.src <= bus_wdata[SRC_POS];
      end
      if (idx == REG_RLD) rld <= bus_wdata[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                   bus_rdata <= '0;
    else if (bus_sel && !bus_wr) bus_rdata <= rd_hit ? rd_word : '0;
  end

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(bus_sel && !bus_wr) |=> $stable(bus_rdata)); // R2
  AST_BAD_ADDR_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_wr && !addr_ok) |=> (bus_rdata == '0)); // R11
  AST_RLD_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_hit && idx == REG_RLD) |=> (bus_rdata[DATA_W-1:CNT_W] == '0)); // R11
  AST_RLD_KEPT: assert property (@(posedge clk) disable iff (rst)
    !(wr_hit && idx == REG_RLD) |=> $stable(rld)); // R9
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tt_pkg::*;
#(
  parameter int               CNT_W     = 24,
  parameter int               ADDR_W    = 4,
  parameter bit               CAL_NOREF = 1'b0,
  parameter bit               CAL_SKEW  = 1'b0,
  parameter logic [CNT_W-1:0] CAL_TENMS = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_tick,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] rld;
  logic [CNT_W-1:0] cnt;
  logic             wr_cur;
  logic             rd_ctrl;
  logic             hit_zero;
  logic             flag;

  tt_regfile #(
    .CNT_W(CNT_W), .ADDR_W(ADDR_W),
    .CAL_NOREF(CAL_NOREF), .CAL_SKEW(CAL_SKEW), .CAL_TENMS(CAL_TENMS)
  ) u_regs (
    .clk(clk), .rst(rst),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .cnt(cnt), .flag(flag),
    .ctrl(ctrl), .rld(rld), .wr_cur(wr_cur), .rd_ctrl(rd_ctrl),
    .bus_rdata(bus_rdata)
  );

  tt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst),
    .en(ctrl.en), .src(ctrl.src), .ref_tick(ref_tick),
    .wr_cur(wr_cur), .rld(rld),
    .cnt(cnt), .hit_zero(hit_zero)
  );

  tt_flag u_flag (
    .clk(clk), .rst(rst),
    .hit_zero(hit_zero), .rd_ctrl(rd_ctrl), .wr_cur(wr_cur), .ie(ctrl.ie),
    .flag(flag), .irq(irq)
  );

  AST_FLAG_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> (cnt == '0)); // R4
  AST_IRQ_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    irq |-> (cnt == '0 && flag)); // R6
endmodule

// File: tb/tick_timer_test.sv
`timescale 1ns/1ps
module tick_timer_test;
  localparam logic [23:0] TENMS = 24'h0ABCDE;
  localparam logic [3:0] A_CTRL = 4'h0, A_RLD = 4'h4, A_CUR = 4'h8, A_CAL = 4'hC;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ref_tick = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  tick_timer #(.CNT_W(24), .ADDR_W(4), .CAL_NOREF(1'b1), .CAL_SKEW(1'b0), .CAL_TENMS(TENMS)) uut (
    .clk(clk), .rst(rst), .ref_tick(ref_tick),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  // monitor: pops expected items as read data appears
  always begin
    @(posedge clk);
    if (!rst && bus_sel && !bus_wr) begin
      #1;
      if (exp_q.size() == 0) chk("R2 unexpected read", bus_rdata, 32'h0);
      else chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(posedge clk); #1;
    bus_sel = 0;
  endtask

  task automatic rd_tick(input logic [3:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a; ref_tick = 1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(posedge clk); #1;
    bus_sel = 0; ref_tick = 0;
  endtask

  task automatic pulse(input logic exp_irq, input string tag);
    @(negedge clk);
    ref_tick = 1;
    @(posedge clk); #1;
    chk(tag, {31'b0, irq}, {31'b0, exp_irq});
    ref_tick = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 rdata", bus_rdata, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    rst = 0;
    rd(A_CTRL, 32'h0, "R1 ctrl");
    rd(A_RLD, 32'h0, "R1 reload");
    rd(A_CUR, 32'h0, "R1 count");
    // R10 calibration
    rd(A_CAL, {1'b1, 1'b0, 6'b0, TENMS}, "R10 cal");
    wr(A_CAL, 32'hFFFF_FFFF);
    rd(A_CAL, {1'b1, 1'b0, 6'b0, TENMS}, "R10 cal after write");
    idle(2);
    chk("R2 rdata holds", bus_rdata, {1'b1, 1'b0, 6'b0, TENMS});

    // R3 core clock mode, back-to-back count reads
    wr(A_RLD, 32'd5);
    wr(A_CTRL, 32'h5);
    rd(A_CUR, 32'd0, "R3 core first");
    rd(A_CUR, 32'd5, "R4 core reload");
    rd(A_CUR, 32'd4, "R3 core step");
    wr(A_CTRL, 32'h0);

    // R5 clear, then reference mode
    wr(A_CUR, 32'hDEAD);
    rd(A_CUR, 32'd0, "R5 cleared");
    wr(A_RLD, 32'd3);
    wr(A_CTRL, 32'h3);
    idle(4);
    rd(A_CUR, 32'd0, "R3 no tick holds");
    pulse(0, "R6 no irq load");
    rd(A_CUR, 32'd3, "R4 load from zero");
    pulse(0, "R6 no irq 3-2");
    pulse(0, "R6 no irq 2-1");
    rd(A_CTRL, 32'h3, "R2 ctrl readback");
    pulse(1, "R6 irq on zero");
    rd(A_CUR, 32'd0, "R4 reached zero");
    rd(A_CTRL, 32'h0001_0003, "R4 flag set");
    rd(A_CTRL, 32'h3, "R7 flag cleared by read");
    pulse(0, "R6 irq single cycle");

    // R9 reload change mid count
    wr(A_RLD, 32'd6);
    rd(A_CUR, 32'd3, "R9 count unchanged");
    pulse(0, "R9 step"); pulse(0, "R9 step"); pulse(1, "R6 irq again");
    pulse(0, "R9 reload");
    rd(A_CUR, 32'd6, "R9 new reload used");
    rd(A_CTRL, 32'h0001_0003, "R4 flag again");

    // R6 interrupt disabled
    wr(A_CTRL, 32'h1);
    for (int i = 0; i < 6; i++) pulse(0, "R6 no irq when ie off");
    rd(A_CTRL, 32'h0001_0001, "R6 flag without irq");

    // R7 read in the same cycle as the zero step
    pulse(0, "R7 reload");
    for (int i = 0; i < 5; i++) pulse(0, "R7 count");
    rd_tick(A_CTRL, 32'h1, "R7 old flag returned");
    rd(A_CTRL, 32'h0001_0001, "R7 set wins over clear");
    rd(A_CTRL, 32'h1, "R7 cleared next read");

    // R5 write to count clears flag
    wr(A_RLD, 32'd1);
    pulse(0, "R5 load 1");
    pulse(0, "R5 hit zero");
    pulse(0, "R5 load 1 again");
    wr(A_CUR, 32'h1234_5678);
    rd(A_CTRL, 32'h1, "R5 flag cleared");
    rd(A_CUR, 32'd0, "R5 count zero");

    // R3 disabled
    wr(A_RLD, 32'd4);
    wr(A_CTRL, 32'h0);
    pulse(0, "R3 off"); pulse(0, "R3 off");
    rd(A_CUR, 32'd0, "R3 disabled ref");
    wr(A_CTRL, 32'h4);
    idle(5);
    rd(A_CUR, 32'd0, "R3 disabled core");
    wr(A_CTRL, 32'h1);
    pulse(0, "R3 on");
    wr(A_CTRL, 32'h0);
    pulse(0, "R3 off"); pulse(0, "R3 off");
    rd(A_CUR, 32'd4, "R3 held when off");

    // R8 reload of zero parks
    wr(A_CUR, 32'h0);
    wr(A_RLD, 32'h0);
    wr(A_CTRL, 32'h3);
    for (int i = 0; i < 4; i++) pulse(0, "R8 no irq");
    rd(A_CUR, 32'd0, "R8 parked");
    rd(A_CTRL, 32'h3, "R8 no flag");
    wr(A_CTRL, 32'h7);
    idle(5);
    rd(A_CTRL, 32'h7, "R8 no flag core");
    rd(A_CUR, 32'd0, "R8 parked core");
    wr(A_CTRL, 32'h0);

    // R11 reserved bits and addresses
    wr(4'h5, 32'h00FF_FFFF);
    rd(A_RLD, 32'h0, "R11 unaligned write ignored");
    rd(4'h6, 32'h0, "R11 unaligned read zero");
    wr(A_CTRL, 32'hFFFF_FFF8);
    rd(A_CTRL, 32'h0, "R11 reserved ctrl bits");
    wr(A_RLD, 32'hFFFF_FFFF);
    rd(A_RLD, 32'h00FF_FFFF, "R11 reload upper bits");

    idle(3);
    chk("R2 queue drained", exp_q.size(), 32'd0);
    finish_up();
  end
endmodule